// File: doc/BRIEF.md
# Hashed direct-mapped translation buffer

This block keeps recently used virtual-to-physical page translations in a small direct-mapped table. Each virtual page number (VPN) goes to one slot only. The slot index is a hash that folds the top index-width bits of the VPN onto its bottom index-width bits. Without that fold, runs of neighbouring pages would share a few slots.

A requester presents a VPN on the lookup port. If the slot holds a valid entry with the same VPN, the block returns the physical page number (PPN) and the permission bits one cycle later. Otherwise the block clears the slot's valid bit and asks an external page-table port for the PPN. When the answer arrives, the block returns it to the requester and writes the VPN and PPN into the slot, marked valid with read/write permission. A flush input clears every slot, as a context switch needs. The lookup port is not ready while a refill is pending.

Top module: `xlat_cache`

## Requirements
- R1: When an accepted lookup finds its slot valid with an equal stored VPN, rsp_valid is high in the next cycle with rsp_hit=1, the stored PPN and rsp_perm=2'b11 (bit 1 read, bit 0 write). No page-table request is made.
- R2: The slot index is req_vpn[19:16] XOR req_vpn[3:0]. Because of this, 16 pages that differ only in their low 4 bits occupy 16 different slots and all hit afterwards.
- R3: When an accepted lookup misses, pt_req_valid rises in the next cycle with pt_req_vpn equal to the looked-up VPN. Both stay unchanged until pt_req_ready is seen high, and pt_req_valid drops after that cycle.
- R4: In the cycle after pt_rsp_valid, rsp_valid is high with rsp_hit=0, rsp_ppn equal to pt_rsp_ppn and rsp_perm=2'b11. The entry is installed, so a later lookup of the same VPN hits with that PPN.
- R5: A missing lookup replaces whatever entry its slot held. A page that was displaced this way misses on its next lookup.
- R6: req_ready is low from the cycle after a missing lookup is accepted until the response cycle has passed.
- R7: A cycle with flush high invalidates all slots, so every later lookup misses until it is refilled. req_ready is low in that cycle.
- R8: When flush and pt_rsp_valid are high in the same cycle, the response is still returned to the requester, but the entry is not installed.
- R9: After reset every slot is invalid, req_ready is high, and rsp_valid and pt_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ready | output | 1 | Lookup port can accept a request |
| rsp_valid | output | 1 | Lookup result is present (one cycle) |
| rsp_hit | output | 1 | Result came from the table |
| rsp_ppn | output | 20 | Physical page number |
| rsp_perm | output | 2 | Permission bits: bit 1 read, bit 0 write |
| pt_req_valid | output | 1 | Page-table request pending |
| pt_req_vpn | output | 20 | VPN sent to the page table |
| pt_req_ready | input | 1 | Page table takes the request |
| pt_rsp_valid | input | 1 | Page-table answer is present |
| pt_rsp_ppn | input | 20 | PPN from the page table |

## Verification
Four families of pages drive the lookup port.
- One page for each slot, chosen by the upper field, fills the table and is then looked up again. This separates the hit path from the miss path.
- Sixteen pages that differ only in their low bits must all stay resident. This shows the hash folds in the low field.
- Sixteen pages whose two fields are equal all land on slot zero. Each replaces the one before it, so only the last one still hits.
- A pair that differs in both fields but shares a slot shows that a match needs the full VPN.

Flushes are issued both while idle and in the same cycle as a page-table answer. The later lookups then show whether the table was cleared and whether the refill was suppressed.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PTREQ  = 2'd1,
        ST_PTWAIT = 2'd2
    } refill_st_e;

    localparam logic [1:0] PERM_RW = 2'b11;

endpackage

// File: rtl/xlat_index_hash.sv
module xlat_index_hash #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 4
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    // fold the top field onto the bottom field
    assign idx = vpn[VPN_W-1 -: IDX_W] ^ vpn[IDX_W-1:0];
endmodule

// File: rtl/xlat_tag_store.sv
module xlat_tag_store #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [VPN_W-1:0] rd_vpn,
    output logic [PPN_W-1:0] rd_ppn,
    output logic [1:0]       rd_perm,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [1:0]       wr_perm
);
    logic [SLOTS-1:0] valid_q;
    logic [SLOTS-1:0] wr_sel;
    logic [SLOTS-1:0] inv_sel;
    logic [VPN_W-1:0] tag_q  [SLOTS];
    logic [PPN_W-1:0] ppn_q  [SLOTS];
    logic [1:0]       perm_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_sel
        assign wr_sel[i]  = wr_en  && (wr_idx  == IDX_W'(i));
        assign inv_sel[i] = inv_en && (inv_idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (rst || flush) begin
                valid_q[i] <= 1'b0;
            end else if (wr_sel[i]) begin
                valid_q[i] <= 1'b1;
            end else if (inv_sel[i]) begin
                valid_q[i] <= 1'b0;
            end
            if (wr_sel[i]) begin
                tag_q[i]  <= wr_vpn;
                ppn_q[i]  <= wr_ppn;
                perm_q[i] <= wr_perm;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_vpn   = tag_q[rd_idx];
    assign rd_ppn   = ppn_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];
endmodule

// File: rtl/xlat_refill_ctrl.sv
module xlat_refill_ctrl
    import xlat_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_ready,
    input  logic             rd_valid,
    input  logic [VPN_W-1:0] rd_vpn,
    input  logic [PPN_W-1:0] rd_ppn,
    input  logic [1:0]       rd_perm,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [1:0]       rsp_perm,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    input  logic             pt_req_ready,
    input  logic             pt_rsp_valid,
    input  logic [PPN_W-1:0] pt_rsp_ppn,
    output logic             inv_en,
    output logic [IDX_W-1:0] inv_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [VPN_W-1:0] wr_vpn,
    output logic [PPN_W-1:0] wr_ppn,
    output logic [1:0]       wr_perm
);
    refill_st_e       st_q;
    logic [VPN_W-1:0] pend_vpn_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             accept;
    logic             lk_hit;
    logic             rsp_done;

    assign req_ready = (st_q == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign lk_hit    = rd_valid && (rd_vpn == req_vpn);
    assign rsp_done  = (st_q == ST_PTWAIT) && pt_rsp_valid;

    // first step of a refill: drop the slot's valid bit
    assign inv_en  = accept && !lk_hit;
    assign inv_idx = req_idx;
    // last step: write tag and data, set valid (flush wins)
    assign wr_en   = rsp_done && !flush;
    assign wr_idx  = pend_idx_q;
    assign wr_vpn  = pend_vpn_q;
    assign wr_ppn  = pt_rsp_ppn;
    assign wr_perm = PERM_RW;

    assign pt_req_valid = (st_q == ST_PTREQ);
    assign pt_req_vpn   = pend_vpn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_ppn    <= '0;
            rsp_perm   <= '0;
            pend_vpn_q <= '0;
            pend_idx_q <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (lk_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_ppn   <= rd_ppn;
                            rsp_perm  <= rd_perm;
                        end else begin
                            st_q       <= ST_PTREQ;
                            pend_vpn_q <= req_vpn;
                            pend_idx_q <= req_idx;
                        end
                    end
                end
                ST_PTREQ: begin
                    if (pt_req_ready) st_q <= ST_PTWAIT;
                end
                ST_PTWAIT: begin
                    if (pt_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_ppn   <= pt_rsp_ppn;
                        rsp_perm  <= PERM_RW;
                        st_q      <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int SLOTS = 16,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [1:0]       rsp_perm,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    input  logic             pt_req_ready,
    input  logic             pt_rsp_valid,
    input  logic [PPN_W-1:0] pt_rsp_ppn
);
    logic [IDX_W-1:0] req_idx;
    logic             rd_valid;
    logic [VPN_W-1:0] rd_vpn;
    logic [PPN_W-1:0] rd_ppn;
    logic [1:0]       rd_perm;
    logic             inv_en, wr_en;
    logic [IDX_W-1:0] inv_idx, wr_idx;
    logic [VPN_W-1:0] wr_vpn;
    logic [PPN_W-1:0] wr_ppn;
    logic [1:0]       wr_perm;

    xlat_index_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
        .vpn (req_vpn),
        .idx (req_idx)
    );

    xlat_tag_store #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rd_idx   (req_idx),
        .rd_valid (rd_valid),
        .rd_vpn   (rd_vpn),
        .rd_ppn   (rd_ppn),
        .rd_perm  (rd_perm),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (wr_vpn),
        .wr_ppn   (wr_ppn),
        .wr_perm  (wr_perm)
    );

    xlat_refill_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .req_valid    (req_valid),
        .req_vpn      (req_vpn),
        .req_idx      (req_idx),
        .req_ready    (req_ready),
        .rd_valid     (rd_valid),
        .rd_vpn       (rd_vpn),
        .rd_ppn       (rd_ppn),
        .rd_perm      (rd_perm),
        .rsp_valid    (rsp_valid),
        .rsp_hit      (rsp_hit),
        .rsp_ppn      (rsp_ppn),
        .rsp_perm     (rsp_perm),
        .pt_req_valid (pt_req_valid),
        .pt_req_vpn   (pt_req_vpn),
        .pt_req_ready (pt_req_ready),
        .pt_rsp_valid (pt_rsp_valid),
        .pt_rsp_ppn   (pt_rsp_ppn),
        .inv_en       (inv_en),
        .inv_idx      (inv_idx),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_vpn       (wr_vpn),
        .wr_ppn       (wr_ppn),
        .wr_perm      (wr_perm)
    );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_perm,
    input logic             pt_req_valid,
    input logic [VPN_W-1:0] pt_req_vpn,
    input logic             pt_req_ready
);
    // R1
    hit_perm_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_perm == 2'b11));

    // R3
    ptreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_vpn)));

    // R6
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        pt_req_valid |-> !req_ready);

    // R7
    flush_nohit_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !rsp_hit);

    // R1
    accept_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid || pt_req_valid));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !pt_req_valid));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_perm     (rsp_perm),
    .pt_req_valid (pt_req_valid),
    .pt_req_vpn   (pt_req_vpn),
    .pt_req_ready (pt_req_ready)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vpn = '0;
    logic          req_ready;
    logic          rsp_valid, rsp_hit;
    logic [PW-1:0] rsp_ppn;
    logic [1:0]    rsp_perm;
    logic          pt_req_valid;
    logic [VW-1:0] pt_req_vpn;
    logic          pt_req_ready = 1'b0;
    logic          pt_rsp_valid = 1'b0;
    logic [PW-1:0] pt_rsp_ppn = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int hits_seen;

    logic          m_valid [NS];
    logic [VW-1:0] m_vpn   [NS];
    logic [PW-1:0] m_ppn   [NS];

    xlat_cache #(.VPN_W(VW), .PPN_W(PW), .SLOTS(NS)) dut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn), .pt_req_ready(pt_req_ready),
        .pt_rsp_valid(pt_rsp_valid), .pt_rsp_ppn(pt_rsp_ppn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int slot_of(logic [VW-1:0] v);
        return int'(v[19:16] ^ v[3:0]);
    endfunction

    function automatic logic [PW-1:0] pt_of(logic [VW-1:0] v);
        return PW'(v * 20'd3 + 20'h00777);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NS; i++) m_valid[i] = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        #1 check("R7 req_ready during flush", 32'(req_ready), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        model_clear();
    endtask

    // one lookup; a miss is served by the page table with the given waits
    task automatic lookup(logic [VW-1:0] v, int hold, bit flush_at_rsp);
        int  s;
        bit  exp_hit;
        s = slot_of(v);
        exp_hit = m_valid[s] && (m_vpn[s] == v);
        @(negedge clk);
        check("R6 req_ready idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vpn   = v;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            hits_seen++;
            check("R1 hit rsp_valid", 32'(rsp_valid), 32'd1);
            check("R1 hit flag", 32'(rsp_hit), 32'd1);
            check("R1 hit ppn", 32'(rsp_ppn), 32'(m_ppn[s]));
            check("R1 hit perm", 32'(rsp_perm), 32'd3);
            check("R1 no pt request", 32'(pt_req_valid), 32'd0);
        end else begin
            check("R5 miss rsp_valid", 32'(rsp_valid), 32'd0);
            check("R3 pt_req_valid", 32'(pt_req_valid), 32'd1);
            check("R3 pt_req_vpn", 32'(pt_req_vpn), 32'(v));
            check("R6 req_ready in refill", 32'(req_ready), 32'd0);
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                check("R3 pt_req held", 32'(pt_req_valid), 32'd1);
                check("R3 pt_req_vpn held", 32'(pt_req_vpn), 32'(v));
            end
            pt_req_ready = 1'b1;
            @(negedge clk);
            pt_req_ready = 1'b0;
            check("R3 pt_req dropped", 32'(pt_req_valid), 32'd0);
            @(negedge clk);
            check("R6 req_ready awaiting answer", 32'(req_ready), 32'd0);
            pt_rsp_valid = 1'b1;
            pt_rsp_ppn   = pt_of(v);
            flush        = flush_at_rsp;
            @(negedge clk);
            pt_rsp_valid = 1'b0;
            flush        = 1'b0;
            check("R4 rsp_valid", 32'(rsp_valid), 32'd1);
            check("R4 rsp_hit", 32'(rsp_hit), 32'd0);
            check("R4 rsp_ppn", 32'(rsp_ppn), 32'(pt_of(v)));
            check("R4 rsp_perm", 32'(rsp_perm), 32'd3);
            if (flush_at_rsp) begin
                model_clear();
            end else begin
                m_valid[s] = 1'b1;
                m_vpn[s]   = v;
                m_ppn[s]   = pt_of(v);
            end
        end
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check("R9 req_ready", 32'(req_ready), 32'd1);
        check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9 pt_req_valid", 32'(pt_req_valid), 32'd0);
        rst = 1'b0;

        // fill each slot through the upper field, then revisit
        hits_seen = 0;
        for (int k = 0; k < NS; k++) lookup(VW'(k) << 16 | 20'h0AB00, k % 3, 1'b0);
        check("R9 empty after reset: no hits", 32'(hits_seen), 32'd0);
        hits_seen = 0;
        for (int k = 0; k < NS; k++) lookup(VW'(k) << 16 | 20'h0AB00, 0, 1'b0);
        check("R4 refilled entries hit", 32'(hits_seen), 32'(NS));

        // low-bit neighbours must all stay resident
        do_flush();
        for (int k = 0; k < NS; k++) lookup(20'h5C3A0 | VW'(k), 1, 1'b0);
        hits_seen = 0;
        for (int k = 0; k < NS; k++) lookup(20'h5C3A0 | VW'(k), 0, 1'b0);
        check("R2 low-bit neighbours all hit", 32'(hits_seen), 32'(NS));

        // equal fields: all on slot zero, each replaces the last
        for (int k = 0; k < NS; k++) lookup((VW'(k) << 16) | 20'h01230 | VW'(k), 0, 1'b0);
        hits_seen = 0;
        for (int k = 0; k < NS; k++) lookup((VW'(k) << 16) | 20'h01230 | VW'(k), 0, 1'b0);
        check("R5 chain on slot 0: no hits", 32'(hits_seen), 32'd0);
        hits_seen = 0;
        lookup(20'hF123F, 0, 1'b0);
        check("R5 last in chain hits", 32'(hits_seen), 32'd1);

        // same slot, different VPN
        lookup(20'h12345, 2, 1'b0);
        hits_seen = 0;
        lookup(20'h02344, 0, 1'b0);
        check("R5 conflicting vpn misses", 32'(hits_seen), 32'd0);
        lookup(20'h12345, 0, 1'b0);
        check("R5 displaced page misses", 32'(hits_seen), 32'd0);

        // flush clears everything
        lookup(20'h77777, 0, 1'b0);
        do_flush();
        hits_seen = 0;
        lookup(20'h77777, 0, 1'b0);
        lookup(20'h12345, 0, 1'b0);
        check("R7 after flush no hits", 32'(hits_seen), 32'd0);

        // flush in the answer cycle suppresses the install
        lookup(20'h3A5C9, 1, 1'b1);
        hits_seen = 0;
        lookup(20'h3A5C9, 0, 1'b0);
        check("R8 flush beats install", 32'(hits_seen), 32'd0);
        lookup(20'h3A5C9, 0, 1'b0);
        check("R8 later refill installs", 32'(hits_seen), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule